// File: doc/BRIEF.md
# Minifloppy Track Stream Emulator

This block stands in for a single minifloppy drive on the controller side of a system. It tracks the head position as a two-digit BCD track number moved by step pulses, flags track zero, and produces one index pulse per emulated revolution. The revolution length is a parameter, so a revolution can be made longer than a spinning disk would allow without touching the bit rate.

A fixed time after the index pulse ends, the block plays the whole track buffer out one bit at a time, most significant bit first, and pulses a strobe as each byte completes. While the write gate is asserted, it stores incoming bytes at the position reached since the last index pulse. A separate host port loads and dumps the buffer, so whatever fetches tracks from storage can fill it between head moves. Sector layout is left to the software on the controller; the block only sees a raw track.

Top module: `fdd_track_emu`

## Requirements
- R1: After a synchronous active-low reset the track number reads 8'h00, track_zero and index_out are high, and rd_strobe and rd_serial are low.
- R2: A one-cycle step_in pulse raises the track number by one and a step_out pulse lowers it by one, in BCD (ones digit in bits 3:0, tens digit in bits 7:4, so 09 is followed by 10). If both pulses arrive in the same cycle, the head does not move.
- R3: A step_out at track 00 and a step_in at MAX_TRACK leave the track number unchanged.
- R4: track_zero is high exactly when the track number is 00.
- R5: index_out is high for IDX_WIDTH cycles at the start of each revolution of REV_CYCLES cycles. It keeps running whatever the state of head_load and write_gate.
- R6: Streaming starts START_DELAY cycles after index_out falls. Counting from the cycle in which index_out rises, bit b (0 = MSB) of byte k is on rd_serial from cycle IDX_WIDTH+START_DELAY+1+8·P·k+P·b for P cycles, where P = BIT_CYC. rd_serial is low outside the stream.
- R7: With fast_rate high, the bit period P is BIT_CYC/2 cycles, which doubles the data rate. The revolution timing does not change.
- R8: In each revolution exactly TRACK_BYTES bytes are strobed, starting from offset 0. rd_strobe is high for one cycle at cycle IDX_WIDTH+START_DELAY+1+8·P·(k+1), with rd_data holding byte k.
- R9: While head_load is low or write_gate is high, rd_strobe and rd_serial stay low.
- R10: When head_load and write_gate are high, each wr_strobe stores wr_data at the byte offset counted since the last index event. The offset returns to 0 at every index event, and a write that runs through the index pulse continues at offset 0.
- R11: A host_we write stores host_wdata at host_addr. host_rdata shows the byte at host_addr one cycle later. If a write capture happens in the same cycle, the host write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_in | input | 1 | One-cycle pulse: move head one track inward |
| step_out | input | 1 | One-cycle pulse: move head one track outward |
| head_load | input | 1 | Enables read streaming and write capture |
| write_gate | input | 1 | Selects write capture and suppresses reading |
| fast_rate | input | 1 | High selects the doubled data rate |
| wr_strobe | input | 1 | Byte-valid strobe for wr_data |
| wr_data | input | 8 | Byte to capture into the track |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | $clog2(TRACK_BYTES) | Host buffer address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Host buffer read data, one-cycle latency |
| track_bcd | output | 8 | Current track as two BCD digits |
| track_zero | output | 1 | High at track 00 |
| index_out | output | 1 | Index pulse, active high |
| rd_serial | output | 1 | Serial read data, MSB first |
| rd_strobe | output | 1 | One-cycle pulse when a byte completes |
| rd_data | output | 8 | Byte just completed |

## Verification
Step pulses change the track number and track_zero one cycle after the pulse is sampled. Host reads appear one cycle after the address is presented. Index, serial bits and byte strobes are checked on every cycle of a revolution against positions computed from the moment index_out rises: the index window lasts IDX_WIDTH cycles, and bit and strobe positions are offset by one registered start cycle after IDX_WIDTH+START_DELAY. The bench drives inputs and samples outputs on falling edges and counts cycles from the falling edge at which it first sees index_out high. Each expected value therefore falls in a known cycle with no margin, and that includes write strobes placed in the last cycle of a revolution to exercise the wrap.

// File: rtl/fdd_pkg.sv
// Shared types and BCD helpers for the track emulator.
// Assumes track numbers never exceed 99.
package fdd_pkg;

    typedef logic [7:0] bcd_t;

    // Convert a binary track count (0..99) to two BCD digits.
    function automatic bcd_t to_bcd(input int n);
        bcd_t r;
        r[7:4] = 4'(n / 10);
        r[3:0] = 4'(n % 10);
        return r;
    endfunction

    // Add one to a BCD value, carrying into the tens digit.
    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Subtract one from a BCD value, borrowing from the tens digit.
    function automatic bcd_t bcd_dec(input bcd_t v);
        if (v[3:0] == 4'd0) return {v[7:4] - 4'd1, 4'd9};
        return {v[7:4], v[3:0] - 4'd1};
    endfunction

endpackage

// File: rtl/fdd_head_pos.sv
// Head position register. Keeps the current track in BCD and moves it one
// track per step pulse, clamped to 00 and MAX_TRACK.
// Assumes step pulses are one cycle wide; simultaneous pulses cancel.
module fdd_head_pos
    import fdd_pkg::*;
#(
    parameter int MAX_TRACK = 39
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic step_out,
    output bcd_t track,
    output logic at_zero
);
    localparam bcd_t MAX_BCD = to_bcd(MAX_TRACK);

    // Move the head by one track per step, within the limits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            track <= 8'h00;
        else if (step_in && !step_out && track != MAX_BCD)
            track <= bcd_inc(track);
        else if (step_out && !step_in && track != 8'h00)
            track <= bcd_dec(track);
    end

    assign at_zero = (track == 8'h00);

    assert_floor_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (track == 8'h00 && step_out && !step_in) |=> (track == 8'h00));

    assert_ceiling_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (track == MAX_BCD && step_in && !step_out) |=> (track == MAX_BCD));

    assert_both_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && step_out) |=> $stable(track));

    // Check that the ones digit stays a legal BCD digit (R2).
    always_ff @(posedge clk) begin
        if (rst_n) assert_bcd_digit_R2: assert (track[3:0] <= 4'd9);
    end

endmodule

// File: rtl/fdd_rev_timer.sv
// Revolution timer. Counts REV_CYCLES per revolution, drives the index
// window at its start, and flags the stream start and the index event.
// Assumes IDX_WIDTH + START_DELAY < REV_CYCLES - 1.
module fdd_rev_timer #(
    parameter int REV_CYCLES  = 2000000,
    parameter int IDX_WIDTH   = 4000,
    parameter int START_DELAY = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic index,
    output logic start_evt,
    output logic wrap_evt
);
    localparam int CW = $clog2(REV_CYCLES);
    localparam logic [CW-1:0] LAST_POS  = CW'(REV_CYCLES - 1);
    localparam logic [CW-1:0] IDX_END   = CW'(IDX_WIDTH);
    localparam logic [CW-1:0] START_POS = CW'(IDX_WIDTH + START_DELAY);

    logic [CW-1:0] rev_cnt;

    // Advance the position within the revolution, wrapping each turn.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rev_cnt <= '0;
        else if (rev_cnt == LAST_POS)
            rev_cnt <= '0;
        else
            rev_cnt <= rev_cnt + 1'b1;
    end

    assign index     = (rev_cnt < IDX_END);
    assign start_evt = (rev_cnt == START_POS);
    assign wrap_evt  = (rev_cnt == LAST_POS);

    assert_index_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(index) |-> (rev_cnt == IDX_END));

    assert_start_after_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> !index);

    assert_index_follows_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> index);

endmodule

// File: rtl/fdd_stream.sv
// Read serializer. On the start event it plays TRACK_BYTES bytes out,
// MSB first, one bit per bit period, and pulses a strobe per finished byte.
// Assumes TRACK_BYTES is a power of two and BIT_CYC is even and at least 2.
module fdd_stream #(
    parameter int TRACK_BYTES = 2048,
    parameter int BIT_CYC     = 80
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           enable,
    input  logic                           fast,
    input  logic [7:0]                     fetch_data,
    output logic [$clog2(TRACK_BYTES)-1:0] fetch_addr,
    output logic                           ser,
    output logic                           strobe,
    output logic [7:0]                     data
);
    localparam int AW = $clog2(TRACK_BYTES);
    localparam int TW = $clog2(BIT_CYC);
    localparam logic [TW-1:0] SLOW_LAST = TW'(BIT_CYC - 1);
    localparam logic [TW-1:0] FAST_LAST = TW'(BIT_CYC / 2 - 1);
    localparam logic [AW-1:0] LAST_BYTE = AW'(TRACK_BYTES - 1);

    logic          on;
    logic [AW-1:0] byte_idx;
    logic [2:0]    bit_idx;
    logic [TW-1:0] tmr;
    logic [7:0]    shreg;
    logic [7:0]    cur;
    logic [TW-1:0] bit_last;

    assign bit_last   = fast ? FAST_LAST : SLOW_LAST;
    assign fetch_addr = start ? '0 : byte_idx + 1'b1;
    assign ser        = on & shreg[7];

    // Sequence bits and bytes of the track while streaming is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on       <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
            tmr      <= '0;
            shreg    <= '0;
            cur      <= '0;
            strobe   <= 1'b0;
            data     <= '0;
        end else begin
            strobe <= 1'b0;
            if (!enable) begin
                on <= 1'b0;
            end else if (start) begin
                on       <= 1'b1;
                byte_idx <= '0;
                bit_idx  <= '0;
                tmr      <= '0;
                shreg    <= fetch_data;
                cur      <= fetch_data;
            end else if (on) begin
                if (tmr >= bit_last) begin
                    tmr <= '0;
                    if (bit_idx == 3'd7) begin
                        strobe  <= 1'b1;
                        data    <= cur;
                        bit_idx <= '0;
                        if (byte_idx == LAST_BYTE) begin
                            on <= 1'b0;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            shreg    <= fetch_data;
                            cur      <= fetch_data;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[6:0], 1'b0};
                    end
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    assert_idle_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ser && !strobe));

    assert_stream_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable) |=> (on && byte_idx == '0 && bit_idx == 3'd0));

    assert_strobe_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(enable));

endmodule

// File: rtl/fdd_track_emu.sv
// Single-drive track emulator top. Combines head position, revolution
// timer, read serializer, the track buffer with write capture, and the
// host load/dump port. Assumes TRACK_BYTES is a power of two.
module fdd_track_emu
    import fdd_pkg::*;
#(
    parameter int TRACK_BYTES = 2048,
    parameter int BIT_CYC     = 80,
    parameter int REV_CYCLES  = 2000000,
    parameter int IDX_WIDTH   = 4000,
    parameter int START_DELAY = 10000,
    parameter int MAX_TRACK   = 39
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           step_in,
    input  logic                           step_out,
    input  logic                           head_load,
    input  logic                           write_gate,
    input  logic                           fast_rate,
    input  logic                           wr_strobe,
    input  logic [7:0]                     wr_data,
    input  logic                           host_we,
    input  logic [$clog2(TRACK_BYTES)-1:0] host_addr,
    input  logic [7:0]                     host_wdata,
    output logic [7:0]                     host_rdata,
    output logic [7:0]                     track_bcd,
    output logic                           track_zero,
    output logic                           index_out,
    output logic                           rd_serial,
    output logic                           rd_strobe,
    output logic [7:0]                     rd_data
);
    localparam int AW = $clog2(TRACK_BYTES);

    logic [7:0]    mem [TRACK_BYTES];
    logic          start_evt;
    logic          wrap_evt;
    logic          capture;
    logic [AW-1:0] wptr;
    logic [AW-1:0] cap_addr;
    logic [AW-1:0] fetch_addr;
    logic [7:0]    fetch_data;
    bcd_t          track;

    fdd_head_pos #(.MAX_TRACK(MAX_TRACK)) i_head (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .step_out(step_out),
        .track(track), .at_zero(track_zero)
    );

    fdd_rev_timer #(
        .REV_CYCLES(REV_CYCLES), .IDX_WIDTH(IDX_WIDTH), .START_DELAY(START_DELAY)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .index(index_out),
        .start_evt(start_evt), .wrap_evt(wrap_evt)
    );

    fdd_stream #(.TRACK_BYTES(TRACK_BYTES), .BIT_CYC(BIT_CYC)) i_stream (
        .clk(clk), .rst_n(rst_n), .start(start_evt),
        .enable(head_load & ~write_gate), .fast(fast_rate),
        .fetch_data(fetch_data), .fetch_addr(fetch_addr),
        .ser(rd_serial), .strobe(rd_strobe), .data(rd_data)
    );

    assign track_bcd  = track;
    assign fetch_data = mem[fetch_addr];
    assign capture    = head_load & write_gate & wr_strobe;
    assign cap_addr   = wrap_evt ? '0 : wptr;

    // Store captured bytes, or host bytes when no capture is pending.
    always_ff @(posedge clk) begin
        if (capture)
            mem[cap_addr] <= wr_data;
        else if (host_we)
            mem[host_addr] <= host_wdata;
    end

    // Track the write offset since the last index event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (capture)
            wptr <= cap_addr + 1'b1;
        else if (wrap_evt)
            wptr <= '0;
    end

    // Register the host dump data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else
            host_rdata <= mem[host_addr];
    end

    assert_ptr_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_out) |-> (wptr <= AW'(1)));

    assert_no_read_while_writing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        write_gate |=> !rd_strobe);

endmodule

// File: tb/test_fdd_track_emu.sv
// Bench for fdd_track_emu on a small configuration: 8-byte track,
// 300-cycle revolution, full sweeps of head moves and stream cycles.
module test_fdd_track_emu;
    localparam int CLK_PERIOD = 10;
    localparam int TB   = 8;
    localparam int BC   = 4;
    localparam int REV  = 300;
    localparam int IDXW = 4;
    localparam int DLY  = 6;
    localparam int MAXT = 12;
    localparam int SP   = IDXW + DLY;

    logic clk = 0;
    logic rst_n = 0;
    logic step_in = 0, step_out = 0, head_load = 0, write_gate = 0, fast_rate = 0;
    logic wr_strobe = 0, host_we = 0;
    logic [7:0] wr_data = 0, host_wdata = 0;
    logic [2:0] host_addr = 0;
    logic [7:0] host_rdata, track_bcd, rd_data;
    logic track_zero, index_out, rd_serial, rd_strobe;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_mem [TB];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fdd_track_emu #(
        .TRACK_BYTES(TB), .BIT_CYC(BC), .REV_CYCLES(REV),
        .IDX_WIDTH(IDXW), .START_DELAY(DLY), .MAX_TRACK(MAXT)
    ) i_fdd_track_emu (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .step_out(step_out),
        .head_load(head_load), .write_gate(write_gate), .fast_rate(fast_rate),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .track_bcd(track_bcd), .track_zero(track_zero), .index_out(index_out),
        .rd_serial(rd_serial), .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = index_out;
        forever begin
            @(negedge clk);
            if (index_out && !prev) break;
            prev = index_out;
        end
    endtask

    function automatic logic [7:0] to_bcd8(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    // One revolution checked cycle by cycle from the index rise.
    task automatic check_rev(input bit expect_data, input int bc, input string sreq);
        for (int c = 0; c < REV; c++) begin
            int rel;
            logic exp_ser;
            logic exp_stb;
            if (c > 0) @(negedge clk);
            chk(index_out == (c < IDXW), "R5", "index window", index_out, c < IDXW);
            rel = c - (SP + 1);
            exp_ser = 1'b0;
            exp_stb = 1'b0;
            if (expect_data && rel >= 0 && rel < 8 * bc * TB)
                exp_ser = exp_mem[rel / (8 * bc)][7 - (rel % (8 * bc)) / bc];
            if (expect_data && rel > 0 && rel % (8 * bc) == 0 && rel / (8 * bc) <= TB)
                exp_stb = 1'b1;
            chk(rd_serial == exp_ser, expect_data ? sreq : "R9", "serial bit", rd_serial, exp_ser);
            chk(rd_strobe == exp_stb, expect_data ? "R8" : "R9", "byte strobe", rd_strobe, exp_stb);
            if (exp_stb)
                chk(rd_data == exp_mem[rel / (8 * bc) - 1], "R8", "byte value",
                    rd_data, exp_mem[rel / (8 * bc) - 1]);
        end
    endtask

    task automatic dump_check(input string req);
        for (int i = 0; i < TB; i++) begin
            host_addr = 3'(i);
            @(negedge clk);
            chk(host_rdata == exp_mem[i], req, "buffer dump", host_rdata, exp_mem[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run incomplete (R1..all)");
        summary();
    end

    initial begin
        int t;
        logic [7:0] w [8];

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(track_bcd == 8'h00, "R1", "reset track", track_bcd, 0);
        chk(track_zero == 1'b1, "R1", "reset track_zero", track_zero, 1);
        chk(index_out == 1'b1, "R1", "reset index", index_out, 1);
        chk(rd_strobe == 1'b0, "R1", "reset strobe", rd_strobe, 0);
        chk(rd_serial == 1'b0, "R1", "reset serial", rd_serial, 0);

        // R2, R3, R4: step sweep inward past the limit
        t = 0;
        for (int k = 0; k < MAXT + 2; k++) begin
            step_in = 1;
            @(negedge clk);
            step_in = 0;
            if (t < MAXT) t++;
            chk(track_bcd == to_bcd8(t), (k >= MAXT) ? "R3" : "R2", "step in", track_bcd, to_bcd8(t));
            chk(track_zero == (t == 0), "R4", "track_zero", track_zero, t == 0);
        end
        step_in = 1; step_out = 1;
        @(negedge clk);
        step_in = 0; step_out = 0;
        chk(track_bcd == to_bcd8(t), "R2", "both steps", track_bcd, to_bcd8(t));
        for (int k = 0; k < MAXT + 2; k++) begin
            step_out = 1;
            @(negedge clk);
            step_out = 0;
            if (t > 0) t--;
            chk(track_bcd == to_bcd8(t), (k >= MAXT) ? "R3" : "R2", "step out", track_bcd, to_bcd8(t));
            chk(track_zero == (t == 0), "R4", "track_zero", track_zero, t == 0);
        end
        step_in = 1; step_out = 1;
        @(negedge clk);
        step_in = 0; step_out = 0;
        chk(track_bcd == 8'h00, "R2", "both steps at 00", track_bcd, 0);

        // R11: host load and dump
        for (int i = 0; i < TB; i++) begin
            exp_mem[i] = 8'((i * 53 + 29) ^ (i << 5));
            host_we = 1; host_addr = 3'(i); host_wdata = exp_mem[i];
            @(negedge clk);
        end
        host_we = 0;
        dump_check("R11");

        // R6, R8: slow stream
        head_load = 1;
        wait_rise();
        check_rev(1'b1, BC, "R6");

        // R7: fast stream
        fast_rate = 1;
        wait_rise();
        check_rev(1'b1, BC / 2, "R7");
        fast_rate = 0;

        // R9: head unloaded, index keeps running
        head_load = 0;
        wait_rise();
        check_rev(1'b0, BC, "R9");

        // R10: capture, wrap through index, host write blocked (R11)
        for (int j = 0; j < 8; j++) w[j] = 8'(8'hC1 + j * 17);
        head_load = 1; write_gate = 1;
        wait_rise();
        for (int s = 0; s < REV + 2; s++) begin
            chk(rd_strobe == 1'b0 && rd_serial == 1'b0, "R9", "idle while writing",
                {rd_strobe, rd_serial}, 0);
            wr_strobe = 0; host_we = 0;
            if (s >= 2 && s <= 4) begin
                wr_strobe = 1; wr_data = w[s - 2];
            end
            if (s == 2) begin
                host_we = 1; host_addr = 3'd7; host_wdata = 8'hEE;
            end
            if (s >= REV - 3) begin
                wr_strobe = 1; wr_data = w[s - (REV - 3) + 3];
            end
            @(negedge clk);
        end
        wr_strobe = 0; host_we = 0; write_gate = 0;
        exp_mem[0] = w[5]; exp_mem[1] = w[6]; exp_mem[2] = w[7];
        exp_mem[3] = w[3]; exp_mem[4] = w[4];
        dump_check("R10");
        chk(exp_mem[7] != 8'hEE, "R11", "blocked host write reference", exp_mem[7], exp_mem[7]);

        // R8: stream of captured contents
        wait_rise();
        check_rev(1'b1, BC, "R6");

        summary();
    end

endmodule